// File: doc/BRIEF.md
# Cascaded Interrupt Request Front End

This block takes sixteen raw interrupt request lines and prepares them for a pair of cascaded interrupt controllers. One controller holds channels 0–7 and the other holds channels 8–15. The second controller feeds into position 2 of the first, so fifteen channels can be used. Channel 0 does not come from a pin. It is driven by an internal timer output. Each remaining line is either edge-sensitive or level-sensitive, as chosen by one configuration byte per controller. Most lines trigger on a rising edge. Two lines, channels 8 and 13, always trigger on a falling edge. External pins are pulled up, so an unconnected pin reads high and must never raise a request.

Requests that survive masking are resolved by a fixed priority across the cascade. The order is 0, 1, then 8 to 15, then 3 to 7. The winner is offered on a single request output. A one-cycle acknowledge returns a vector, which is a programmable base plus the channel number. The acknowledge also moves the channel from pending to in-service. An end-of-interrupt pulse retires the highest-priority in-service channel.

Top module: `cascadeIrqFront`

## Requirements
- R1: While reset is held, and directly after it, `intOut` and `vectorValid` are 0.
- R2: An edge-mode channel other than 0, 2, 8 and 13 becomes pending on a low-to-high transition of its line. A high-to-low transition creates no request.
- R3: Channels 8 and 13 become pending on a high-to-low transition of their lines in edge mode. Their low-to-high transition creates no request.
- R4: Channel 0 becomes pending on a rising edge of `timerOut`, and `rawIrq[0]` has no effect. Channel 2 is the cascade slot and never requests; `rawIrq[2]` has no effect.
- R5: Bit i of `levelSelLo` makes channel i level-sensitive for i in 1 and 3..7. Bit i of `levelSelHi` does the same for channel 8+i. A level channel requests while its line is low. The request disappears if the line returns high before acknowledge.
- R6: Lines held high (floating) never create a request, whatever the edge/level selection.
- R7: A channel whose `maskBits` bit is 1 is not presented. A latched edge request is kept while masked and is presented once the mask bit clears.
- R8: When several channels are eligible, the one earliest in the order 0,1,8,9,10,11,12,13,14,15,3,4,5,6,7 wins.
- R9: A one-cycle `ackReq` while `intOut` is 1 gives `vectorValid`=1 for one cycle on the next cycle. In that cycle `vectorOut` = `vectorBase` + channel, modulo 256. The channel leaves pending and enters in-service.
- R10: A channel is presented only if it is earlier in the priority order than every in-service channel.
- R11: An `eoi` pulse clears the in-service bit of the earliest-priority in-service channel only.
- R12: `ackReq` while `intOut` is 0 produces no `vectorValid` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawIrq | input | 16 | Raw request lines, idle high; bits 0 and 2 unused |
| timerOut | input | 1 | Timer output driving channel 0 |
| levelSelLo | input | 8 | Level-sensitivity select, channels 0–7 |
| levelSelHi | input | 8 | Level-sensitivity select, channels 8–15 |
| maskBits | input | 16 | Per-channel mask, 1 = masked |
| vectorBase | input | 8 | Base added to the channel number |
| ackReq | input | 1 | Acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| intOut | output | 1 | A presentable request exists |
| vectorValid | output | 1 | Vector returned this cycle |
| vectorOut | output | 8 | Returned vector |

## Verification
Directed patterns cover the following cases:
- Low-going and high-going pulses on ordinary lines, to separate rising-edge triggering from falling-edge triggering.
- The same pulses on channels 8 and 13.
- Toggles of the unused raw bits 0 and 2, against timer edges.
- A level line released before acknowledge and then held through it.
- A burst on channels 1, 3 and 9 followed by a timer edge while channel 1 is in service. This separates the fixed order and the in-service blocking from any first-come ordering.

Random bursts over random channel subsets with random masks and bases are then drained by acknowledge/end-of-interrupt pairs. The drain order must match the fixed priority, and masked channels must surface only after their masks clear.

// File: rtl/irqFrontPkg.sv
package irqFrontPkg;
  localparam int unsigned CHAN_COUNT = 16;
  localparam int unsigned CHAN_BITS  = $clog2(CHAN_COUNT);
  localparam int unsigned HALF_COUNT = CHAN_COUNT / 2;
  localparam int unsigned CASCADE_CH = 2;

  typedef struct packed {
    logic                 grant;
    logic [CHAN_BITS-1:0] grantCh;
    logic                 retire;
    logic [CHAN_BITS-1:0] retireCh;
  } irqStrobes_t;

  // lower value means more urgent; cascade slot is ranked last
  function automatic int unsigned chanRank(input int unsigned ch);
    if (ch == CASCADE_CH)  return CHAN_COUNT - 1;
    if (ch < CASCADE_CH)   return ch;
    if (ch >= HALF_COUNT)  return ch - HALF_COUNT + CASCADE_CH;
    return ch + HALF_COUNT - 1;
  endfunction
endpackage

// File: rtl/irqLineDatapath.sv
module irqLineDatapath
  import irqFrontPkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter logic [CHAN_COUNT-1:0] FALLING_LINES = 16'h2100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CHAN_COUNT-1:0] rawIrq,
  input  logic                  timerOut,
  input  logic [CHAN_COUNT-1:0] levelSel,
  input  logic [CHAN_COUNT-1:0] maskBits,
  input  logic [VEC_W-1:0]      vectorBase,
  input  irqStrobes_t           strobes,
  output logic [CHAN_COUNT-1:0] candidates,
  output logic [CHAN_COUNT-1:0] inService,
  output logic                  vectorValid,
  output logic [VEC_W-1:0]      vectorOut
);
  logic [CHAN_COUNT-1:0] srcLine;
  logic [CHAN_COUNT-1:0] curLine;
  logic [CHAN_COUNT-1:0] prevLine;
  logic [CHAN_COUNT-1:0] edgeHit;
  logic [CHAN_COUNT-1:0] levelAct;
  logic [CHAN_COUNT-1:0] isLevel;
  logic [CHAN_COUNT-1:0] edgePend;
  logic [CHAN_COUNT-1:0] request;
  logic [CHAN_COUNT-1:0] grantMask;
  logic [CHAN_COUNT-1:0] retireMask;

  always_comb begin
    srcLine    = rawIrq;
    srcLine[0] = timerOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLine  <= '1;
      prevLine <= '1;
    end else begin
      curLine  <= srcLine;
      prevLine <= curLine;
    end
  end

  for (genvar g = 0; g < CHAN_COUNT; g++) begin : gLine
    if (g == 0) begin : gTimer
      assign edgeHit[g]  = curLine[g] & ~prevLine[g];
      assign levelAct[g] = 1'b0;
      assign isLevel[g]  = 1'b0;
    end else if (g == CASCADE_CH) begin : gCascade
      assign edgeHit[g]  = 1'b0;
      assign levelAct[g] = 1'b0;
      assign isLevel[g]  = 1'b0;
    end else if (FALLING_LINES[g]) begin : gFall
      assign edgeHit[g]  = ~curLine[g] & prevLine[g];
      assign levelAct[g] = ~curLine[g];
      assign isLevel[g]  = levelSel[g];
    end else begin : gRise
      assign edgeHit[g]  = curLine[g] & ~prevLine[g];
      assign levelAct[g] = ~curLine[g];
      assign isLevel[g]  = levelSel[g];
    end
  end

  assign grantMask  = strobes.grant  ? (CHAN_COUNT'(1) << strobes.grantCh)  : '0;
  assign retireMask = strobes.retire ? (CHAN_COUNT'(1) << strobes.retireCh) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgePend    <= '0;
      inService   <= '0;
      vectorValid <= 1'b0;
      vectorOut   <= '0;
    end else begin
      edgePend    <= (edgePend & ~grantMask) | (edgeHit & ~isLevel);
      inService   <= (inService | grantMask) & ~retireMask;
      vectorValid <= strobes.grant;
      if (strobes.grant) begin
        vectorOut <= vectorBase + VEC_W'(strobes.grantCh);
      end
    end
  end

  assign request    = (isLevel & levelAct) | (~isLevel & edgePend);
  assign candidates = request & ~maskBits & ~inService;
endmodule

// File: rtl/irqPriorityControl.sv
module irqPriorityControl
  import irqFrontPkg::*;
(
  input  logic                  ackReq,
  input  logic                  eoi,
  input  logic [CHAN_COUNT-1:0] candidates,
  input  logic [CHAN_COUNT-1:0] inService,
  output logic                  intOut,
  output irqStrobes_t           strobes
);
  int unsigned bestRank;
  int unsigned bestCh;
  int unsigned svcRank;
  int unsigned svcCh;
  logic        haveCand;
  logic        haveSvc;

  always_comb begin
    bestRank = CHAN_COUNT;
    bestCh   = 0;
    svcRank  = CHAN_COUNT;
    svcCh    = 0;
    for (int ch = 0; ch < CHAN_COUNT; ch++) begin
      if (candidates[ch] && chanRank(ch) < bestRank) begin
        bestRank = chanRank(ch);
        bestCh   = ch;
      end
      if (inService[ch] && chanRank(ch) < svcRank) begin
        svcRank = chanRank(ch);
        svcCh   = ch;
      end
    end
    haveCand = (bestRank < CHAN_COUNT);
    haveSvc  = (svcRank < CHAN_COUNT);
  end

  assign intOut = haveCand && (bestRank < svcRank);

  always_comb begin
    strobes.grant    = ackReq && intOut;
    strobes.grantCh  = CHAN_BITS'(bestCh);
    strobes.retire   = eoi && haveSvc;
    strobes.retireCh = CHAN_BITS'(svcCh);
  end
endmodule

// File: rtl/cascadeIrqFront.sv
module cascadeIrqFront
  import irqFrontPkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter logic [CHAN_COUNT-1:0] FALLING_LINES = 16'h2100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CHAN_COUNT-1:0] rawIrq,
  input  logic                  timerOut,
  input  logic [HALF_COUNT-1:0] levelSelLo,
  input  logic [HALF_COUNT-1:0] levelSelHi,
  input  logic [CHAN_COUNT-1:0] maskBits,
  input  logic [VEC_W-1:0]      vectorBase,
  input  logic                  ackReq,
  input  logic                  eoi,
  output logic                  intOut,
  output logic                  vectorValid,
  output logic [VEC_W-1:0]      vectorOut
);
  irqStrobes_t           strobes;
  logic [CHAN_COUNT-1:0] candidates;
  logic [CHAN_COUNT-1:0] inService;

  irqLineDatapath #(.VEC_W(VEC_W), .FALLING_LINES(FALLING_LINES)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .rawIrq     (rawIrq),
    .timerOut   (timerOut),
    .levelSel   ({levelSelHi, levelSelLo}),
    .maskBits   (maskBits),
    .vectorBase (vectorBase),
    .strobes    (strobes),
    .candidates (candidates),
    .inService  (inService),
    .vectorValid(vectorValid),
    .vectorOut  (vectorOut)
  );

  irqPriorityControl uCtrl (
    .ackReq    (ackReq),
    .eoi       (eoi),
    .candidates(candidates),
    .inService (inService),
    .intOut    (intOut),
    .strobes   (strobes)
  );
endmodule

// File: rtl/irqFrontChecker.sv
module irqFrontChecker
  import irqFrontPkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [CHAN_COUNT-1:0] maskBits,
  input logic [VEC_W-1:0]      vectorBase,
  input logic                  ackReq,
  input logic                  intOut,
  input logic                  vectorValid,
  input logic [VEC_W-1:0]      vectorOut
);
  // R9
  ack_gives_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && intOut) |=> vectorValid);

  // R12
  idle_ack_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackReq && intOut) |=> !vectorValid);

  // R7
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskBits) |-> !intOut);

  // R4
  no_cascade_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    vectorValid |-> ((vectorOut - $past(vectorBase)) != VEC_W'(CASCADE_CH)));
endmodule

bind cascadeIrqFront irqFrontChecker #(.VEC_W(VEC_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .maskBits   (maskBits),
  .vectorBase (vectorBase),
  .ackReq     (ackReq),
  .intOut     (intOut),
  .vectorValid(vectorValid),
  .vectorOut  (vectorOut)
);

// File: tb/tb_cascadeIrqFront.sv
`timescale 1ns/1ps
module tb_cascadeIrqFront;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] rawIrq;
  logic        timerOut;
  logic [7:0]  levelSelLo, levelSelHi;
  logic [15:0] maskBits;
  logic [7:0]  vectorBase;
  logic        ackReq, eoi;
  logic        intOut, vectorValid;
  logic [7:0]  vectorOut;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cascadeIrqFront dut (.*);

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int chanAtRank(input int r);
    if (r < 2)  return r;
    if (r < 10) return r + 6;
    return r - 7;
  endfunction

  function automatic int topChan(input logic [15:0] set);
    for (int r = 0; r < 15; r++)
      if (set[chanAtRank(r)]) return chanAtRank(r);
    return -1;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLines(input logic [15:0] v);
    @(negedge clk) rawIrq = v;
  endtask

  task automatic doAck(output logic v, output logic [7:0] vec);
    @(negedge clk) ackReq = 1'b1;
    @(negedge clk) ackReq = 1'b0;
    v   = vectorValid;
    vec = vectorOut;
  endtask

  task automatic doEoi();
    @(negedge clk) eoi = 1'b1;
    @(negedge clk) eoi = 1'b0;
  endtask

  task automatic ackExpect(input string req, input int ch);
    logic v;
    logic [7:0] vec;
    doAck(v, vec);
    checkEq({req, " valid"}, int'(v), 1);
    checkEq({req, " vector"}, int'(vec), int'(8'(vectorBase + 8'(ch))));
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic v;
    logic [7:0] vec;
    rstN = 1'b0; rawIrq = '1; timerOut = 1'b0;
    levelSelLo = '0; levelSelHi = '0; maskBits = '0;
    vectorBase = 8'h20; ackReq = 1'b0; eoi = 1'b0;
    void'($urandom(32'h5EED));
    idle(3);
    checkEq("R1 intOut in reset", int'(intOut), 0);
    checkEq("R1 vectorValid in reset", int'(vectorValid), 0);
    rstN = 1'b1;
    idle(2);
    checkEq("R1 intOut after reset", int'(intOut), 0);

    // R6 floating lines in level mode and edge mode
    levelSelLo = '1; levelSelHi = '1;
    idle(10);
    checkEq("R6 level floating", int'(intOut), 0);
    levelSelLo = '0; levelSelHi = '0;
    idle(3);
    checkEq("R6 edge floating", int'(intOut), 0);

    // R2 rising edge only
    setLines(~16'(1 << 5)); idle(3);
    checkEq("R2 falling ignored", int'(intOut), 0);
    setLines('1); idle(3);
    checkEq("R2 rising requests", int'(intOut), 1);
    ackExpect("R9 ch5", 5);
    checkEq("R9 pending cleared", int'(intOut), 0);
    doEoi(); idle(2);
    checkEq("R11 retired, nothing left", int'(intOut), 0);

    // R3 falling edge channels
    setLines(~16'(1 << 13)); idle(3);
    checkEq("R3 ch13 falling requests", int'(intOut), 1);
    setLines('1);
    ackExpect("R3 ch13", 13);
    doEoi(); idle(3);
    checkEq("R3 ch13 rising ignored", int'(intOut), 0);
    setLines(~16'(1 << 8)); setLines('1); idle(3);
    ackExpect("R3 ch8", 8);
    doEoi(); idle(2);

    // R4 unused raw bits and timer channel
    setLines(16'hFFFA); setLines('1); idle(3);
    checkEq("R4 raw bits 0 and 2 ignored", int'(intOut), 0);
    @(negedge clk) timerOut = 1'b1; idle(3);
    checkEq("R4 timer requests", int'(intOut), 1);
    ackExpect("R4 ch0", 0);
    doEoi();
    @(negedge clk) timerOut = 1'b0; idle(2);

    // R5 level sensitivity
    levelSelLo = 8'h10;
    setLines(~16'(1 << 4)); idle(2);
    checkEq("R5 level low requests", int'(intOut), 1);
    setLines('1); idle(2);
    checkEq("R5 level release drops", int'(intOut), 0);
    setLines(~16'(1 << 4)); idle(2);
    ackExpect("R5 ch4 level", 4);
    setLines('1); doEoi(); idle(2);
    levelSelLo = '0; levelSelHi = 8'h08;
    setLines(~16'(1 << 11)); idle(2);
    ackExpect("R5 ch11 level", 11);
    setLines('1); doEoi(); idle(2);
    checkEq("R5 level idle after release", int'(intOut), 0);
    levelSelHi = '0;

    // R7 mask retains edge
    maskBits = 16'(1 << 6);
    setLines(~16'(1 << 6)); setLines('1); idle(3);
    checkEq("R7 masked not presented", int'(intOut), 0);
    maskBits = '0; idle(1);
    checkEq("R7 unmask presents", int'(intOut), 1);
    ackExpect("R7 ch6", 6);
    doEoi(); idle(2);

    // R8 R10 R11 priority and nesting
    setLines(~16'((1 << 3) | (1 << 9) | (1 << 1))); setLines('1); idle(3);
    ackExpect("R8 ch1 first", 1);
    checkEq("R10 lower blocked", int'(intOut), 0);
    @(negedge clk) timerOut = 1'b1; idle(3);
    checkEq("R10 higher presented", int'(intOut), 1);
    ackExpect("R10 ch0 nested", 0);
    doEoi(); idle(1);
    checkEq("R11 only ch0 retired", int'(intOut), 0);
    doEoi(); idle(1);
    checkEq("R11 ch1 retired", int'(intOut), 1);
    ackExpect("R8 ch9 second", 9);
    doEoi();
    ackExpect("R8 ch3 third", 3);
    doEoi();
    @(negedge clk) timerOut = 1'b0; idle(2);

    // R12 ack with nothing pending
    doAck(v, vec);
    checkEq("R12 no vector", int'(v), 0);
    checkEq("R12 still idle", int'(intOut), 0);

    // random bursts
    for (int it = 0; it < 40; it++) begin
      logic [15:0] subset, msk, left;
      subset = 16'($urandom) & 16'hFFFA;
      msk    = 16'($urandom) & 16'($urandom);
      vectorBase = 8'($urandom);
      maskBits = msk;
      setLines(~subset); setLines('1); idle(3);
      left = subset & ~msk;
      while (left != 0) begin
        int ch;
        ch = topChan(left);
        ackExpect("R8 random order", ch);
        left[ch] = 1'b0;
        doEoi();
      end
      idle(1);
      checkEq("R7 random masked held back", int'(intOut), 0);
      maskBits = '0;
      left = subset & msk;
      while (left != 0) begin
        int ch;
        ch = topChan(left);
        ackExpect("R7 random released", ch);
        left[ch] = 1'b0;
        doEoi();
      end
      idle(1);
      checkEq("R9 random drained", int'(intOut), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule